// File: doc/BRIEF.md
# Power-up self-diagnostic sequencer

This controller decides whether a sensor interface device may begin normal operation after power-up. It runs the start-up self-checks one at a time in a fixed order. Five of them are external check engines, each started by a single-cycle request and answered with a done strobe that carries a pass flag. After those, the controller starts the oscillator and waits a bounded time for its amplitude and common-mode range faults to clear. It then switches on three downstream stages one by one, holds fault monitoring masked while the circuits settle, and finally applies the power-on-time and gain-target gates.

A failing check ends in one of two ways, depending on how serious it is. Configuration and self-test failures lead to a terminal disabled result. Sensor, capacitor and oscillator failures lead to a recoverable fault result, from which the sequence restarts. The supply-mode input and the restart-after-fault flag decide whether the regulator capacitor test is run.

Top module: `pwrup_diag_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, all requests, enables, the fault mask and the three result outputs are low.
- R2: Check requests are one-hot, last one cycle, and follow the bit order 0 configuration CRC, 1 logic self-test, 2 monitor self-test, 3 sensor-pin test, 4 capacitor test; the next request waits for the done strobe of the previous one.
- R3: A fail reported on request bit 0, 1 or 2 raises `res_disabled`, which then stays high until reset, and no further requests are issued.
- R4: The capacitor test (bit 4) is requested only when `hi_supply` is 1 and the sequence did not start from the fault result.
- R5: A fail on bit 3 or 4 raises `res_fault`; once `ext_fault` is low, the sequence restarts at bit 0 with the capacitor test skipped.
- R6: `osc_en` rises after the last requested check passes; if `osc_flt` is still nonzero `OSC_TMO_CYC` + 1 cycles after that rise, `res_fault` is raised, and clearing by then lets the sequence continue.
- R7: `stage_en` bits rise in order 0, 1, 2, each `STAGGER_CYC` cycles after the previous one, never together.
- R8: `flt_mask` is high for exactly `SETTLE_CYC` + 1 cycles after the last stage is enabled, and `ext_fault` raised inside that window has no effect.
- R9: With `agc_auto` = 1, `gain_ok` = 0 at the final gate gives `res_disabled`; with `gain_ok` = 1, or with `agc_auto` = 0, the result is `res_normal`.
- R10: `res_normal` does not rise before `PON_MIN_CYC` cycles after reset release.
- R11: At most one of `res_normal`, `res_disabled` and `res_fault` is high.
- R12: `ext_fault` while `res_normal` is high gives `res_fault`. Once it is released, the sequence reruns without the capacitor test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_supply | input | 1 | 1 = higher-supply mode, in which the capacitor test is run |
| agc_auto | input | 1 | 1 = automatic gain mode |
| gain_ok | input | 1 | Gain-control output inside its target window |
| ext_fault | input | 1 | Any other active fault |
| chk_done | input | 5 | Done strobes, one per check |
| chk_pass | input | 5 | Pass flags, valid with the done strobe |
| osc_flt | input | 4 | Oscillator amplitude and common-mode under/over-range flags |
| chk_req | output | 5 | Single-cycle check requests |
| osc_en | output | 1 | Oscillator enable |
| stage_en | output | 3 | Front-end, gain and output stage enables |
| flt_mask | output | 1 | Fault monitoring held reset (settle window) |
| res_normal | output | 1 | Normal operation reached |
| res_disabled | output | 1 | Terminal disabled result |
| res_fault | output | 1 | Recoverable fault result |

## Verification
The sequence is run in both supply modes and in both gain modes, so that the capacitor-test skip and the gain gate are each seen taking both paths. A failure is injected at every check position. This separates the checks that lead to the disabled result from those that lead to the fault result, and shows that the request order stops at the failing check. Oscillator faults are cleared at exactly the timeout and one cycle later, which fixes the timeout boundary. Restarts after a sensor-pin failure and after a fault raised during normal operation show that the capacitor test is skipped on re-entry. An external fault raised inside the settle window shows that the mask keeps it from having any effect.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;
  localparam int NCHK = 5;
  localparam logic [2:0] CHK_CRC = 3'd0;
  localparam logic [2:0] CHK_MON = 3'd2;
  localparam logic [2:0] CHK_PIN = 3'd3;
  localparam logic [2:0] CHK_CAP = 3'd4;

  typedef enum logic [3:0] {
    ST_REQ, ST_WAIT, ST_OSC, ST_STAGE, ST_SETTLE,
    ST_FINAL, ST_NORMAL, ST_FAULT, ST_DISABLED
  } seq_state_t;
endpackage

// File: rtl/diag_timer.sv
module diag_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CNT_W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/diag_stagger.sv
module diag_stagger #(
  parameter int STAGES  = 3,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              go,
  output logic [STAGES-1:0] en,
  output logic              all_on
);
  localparam int GAP_W = $clog2(GAP_CYC) + 1;
  localparam int LVL_W = $clog2(STAGES + 1);

  logic [GAP_W-1:0] gap;
  logic [LVL_W-1:0] lvl;
  logic             step;

  assign all_on = &en;
  assign step   = go && !all_on && (gap == GAP_W'(GAP_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      gap <= '0;
      lvl <= '0;
    end else if (go && !all_on) begin
      if (step) begin
        gap <= '0;
        lvl <= lvl + 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr)                     en[i] <= 1'b0;
      else if (step && lvl == LVL_W'(i))  en[i] <= 1'b1;
    end
    if (i > 0) begin : g_ord
      // R7: a stage is never on ahead of its predecessor
      a_r7_stage_order: assert property (@(posedge clk) disable iff (rst)
        en[i] |-> en[i-1]);
    end
  end
endmodule

// File: rtl/pwrup_diag_seq.sv
module pwrup_diag_seq #(
  parameter int STAGES      = 3,
  parameter int STAGGER_CYC = 4,
  parameter int SETTLE_CYC  = 8,
  parameter int OSC_TMO_CYC = 16,
  parameter int PON_MIN_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_supply,
  input  logic              agc_auto,
  input  logic              gain_ok,
  input  logic              ext_fault,
  input  logic [4:0]        chk_done,
  input  logic [4:0]        chk_pass,
  input  logic [3:0]        osc_flt,
  output logic [4:0]        chk_req,
  output logic              osc_en,
  output logic [STAGES-1:0] stage_en,
  output logic              flt_mask,
  output logic              res_normal,
  output logic              res_disabled,
  output logic              res_fault
);
  import diag_seq_pkg::*;

  localparam int MAX_A = (SETTLE_CYC > OSC_TMO_CYC) ? SETTLE_CYC : OSC_TMO_CYC;
  localparam int CNT_W = $clog2(MAX_A + 1);
  localparam int PON_W = $clog2(PON_MIN_CYC + 1);

  seq_state_t       state;
  logic [2:0]       idx;
  logic             from_fault;
  logic             skip_cap;
  logic             tmr_load, tmr_exp, pon_done;
  logic [CNT_W-1:0] tmr_val;
  logic             stg_clr, stg_all;

  assign skip_cap = !hi_supply || from_fault;
  assign tmr_load = !(state == ST_OSC || state == ST_SETTLE);
  assign tmr_val  = (state == ST_STAGE) ? CNT_W'(SETTLE_CYC) : CNT_W'(OSC_TMO_CYC);
  assign stg_clr  = (state == ST_FAULT) || (state == ST_DISABLED);

  diag_timer #(.CNT_W(CNT_W), .RST_VAL(0)) u_win_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  diag_timer #(.CNT_W(PON_W), .RST_VAL(PON_MIN_CYC)) u_pon_tmr (
    .clk(clk), .rst(rst), .load(1'b0), .load_val('0), .expired(pon_done));

  diag_stagger #(.STAGES(STAGES), .GAP_CYC(STAGGER_CYC)) u_stagger (
    .clk(clk), .rst(rst), .clr(stg_clr), .go(state == ST_STAGE),
    .en(stage_en), .all_on(stg_all));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_REQ;
      idx          <= CHK_CRC;
      from_fault   <= 1'b0;
      chk_req      <= '0;
      osc_en       <= 1'b0;
      flt_mask     <= 1'b0;
      res_normal   <= 1'b0;
      res_disabled <= 1'b0;
      res_fault    <= 1'b0;
    end else begin
      chk_req <= '0;
      case (state)
        ST_REQ: begin
          chk_req[idx] <= 1'b1;
          state        <= ST_WAIT;
        end
        ST_WAIT: if (chk_done[idx]) begin
          if (!chk_pass[idx]) begin
            if (idx <= CHK_MON) begin
              state        <= ST_DISABLED;
              res_disabled <= 1'b1;
            end else begin
              state     <= ST_FAULT;
              res_fault <= 1'b1;
            end
          end else if (idx == CHK_CAP || (idx == CHK_PIN && skip_cap)) begin
            state  <= ST_OSC;
            osc_en <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_OSC: begin
          if (osc_flt == '0) begin
            state <= ST_STAGE;
          end else if (tmr_exp) begin
            state     <= ST_FAULT;
            res_fault <= 1'b1;
            osc_en    <= 1'b0;
          end
        end
        ST_STAGE: if (stg_all) begin
          state    <= ST_SETTLE;
          flt_mask <= 1'b1;
        end
        ST_SETTLE: if (tmr_exp) begin
          state    <= ST_FINAL;
          flt_mask <= 1'b0;
        end
        ST_FINAL: begin
          if (ext_fault) begin
            state     <= ST_FAULT;
            res_fault <= 1'b1;
            osc_en    <= 1'b0;
          end else if (pon_done) begin
            if (agc_auto && !gain_ok) begin
              state        <= ST_DISABLED;
              res_disabled <= 1'b1;
              osc_en       <= 1'b0;
            end else begin
              state      <= ST_NORMAL;
              res_normal <= 1'b1;
            end
          end
        end
        ST_NORMAL: if (ext_fault) begin
          state      <= ST_FAULT;
          res_normal <= 1'b0;
          res_fault  <= 1'b1;
          osc_en     <= 1'b0;
        end
        ST_FAULT: begin
          osc_en <= 1'b0;
          if (!ext_fault) begin
            res_fault  <= 1'b0;
            from_fault <= 1'b1;
            idx        <= CHK_CRC;
            state      <= ST_REQ;
          end
        end
        default: osc_en <= 1'b0;
      endcase
    end
  end

  // R2: at most one request, lasting a single cycle
  a_r2_req_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_req));
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    (chk_req != '0) |=> (chk_req == '0));
  // R3: disabled is terminal
  a_r3_disabled_sticky: assert property (@(posedge clk) disable iff (rst)
    res_disabled |=> res_disabled);
  // R11: exclusive results
  a_r11_result_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_normal, res_disabled, res_fault}));
  // R10: normal only after the power-on window
  a_r10_pon_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(res_normal) |-> pon_done);
  // R6: unresolved oscillator faults at timeout lead to the fault result
  a_r6_osc_timeout: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OSC && osc_flt != '0 && tmr_exp) |=> res_fault);
  // R8: mask only while every stage is on
  a_r8_mask_stages: assert property (@(posedge clk) disable iff (rst)
    flt_mask |-> (&stage_en));
endmodule

// File: tb/pwrup_diag_seq_tb_top.sv
module pwrup_diag_seq_tb_top;
  localparam int STAGGER = 4, SETTLE = 8, OSC_TMO = 16, PON = 200;

  typedef struct packed {
    logic       hs;
    logic       agc;
    logic       gok;
    logic [2:0] fidx;   // 7 = no failure
    logic [7:0] oclr;   // cycles the oscillator flags stay up
    logic [1:0] exp;    // 0 normal, 1 disabled, 2 fault
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 3'd7, 8'd3,   2'd0},
    '{1'b0, 1'b0, 1'b0, 3'd7, 8'd3,   2'd0},
    '{1'b1, 1'b1, 1'b1, 3'd7, 8'd3,   2'd0},
    '{1'b1, 1'b1, 1'b0, 3'd7, 8'd3,   2'd1},
    '{1'b1, 1'b0, 1'b0, 3'd0, 8'd3,   2'd1},
    '{1'b0, 1'b0, 1'b0, 3'd1, 8'd3,   2'd1},
    '{1'b1, 1'b0, 1'b0, 3'd2, 8'd3,   2'd1},
    '{1'b1, 1'b0, 1'b0, 3'd3, 8'd3,   2'd2},
    '{1'b1, 1'b0, 1'b0, 3'd4, 8'd3,   2'd2},
    '{1'b0, 1'b0, 1'b0, 3'd7, 8'd200, 2'd2},
    '{1'b1, 1'b0, 1'b0, 3'd7, 8'd16,  2'd0},
    '{1'b1, 1'b0, 1'b0, 3'd7, 8'd17,  2'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic hi_supply = 1'b0, agc_auto = 1'b0, gain_ok = 1'b0, ext_fault = 1'b0;
  logic [4:0] chk_done = '0, chk_pass = '0, chk_req;
  logic [3:0] osc_flt = '0;
  logic osc_en, flt_mask, res_normal, res_disabled, res_fault;
  logic [2:0] stage_en;

  pwrup_diag_seq dut_i (
    .clk(clk), .rst(rst), .hi_supply(hi_supply), .agc_auto(agc_auto),
    .gain_ok(gain_ok), .ext_fault(ext_fault), .chk_done(chk_done),
    .chk_pass(chk_pass), .osc_flt(osc_flt), .chk_req(chk_req),
    .osc_en(osc_en), .stage_en(stage_en), .flt_mask(flt_mask),
    .res_normal(res_normal), .res_disabled(res_disabled), .res_fault(res_fault));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, req_n = 0, pulse_err = 0, mask_cnt = 0, normal_cyc = -1;
  int req_log [0:15];
  int rise [0:2];
  logic [4:0] fail_bits = '0;
  logic fail_once = 1'b0;
  int oclr = 0;
  int inj_mode = 0, inj_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  initial begin
    logic [4:0] prev_req = '0;
    logic [2:0] prev_stg = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (chk_req != '0 && prev_req != '0) pulse_err++;
      if ($countones(chk_req) > 1) pulse_err++;
      for (int i = 0; i < 5; i++)
        if (chk_req[i] && prev_req == '0) begin
          if (req_n < 16) req_log[req_n] = i;
          req_n++;
        end
      for (int i = 0; i < 3; i++)
        if (stage_en[i] && !prev_stg[i]) rise[i] = cyc;
      if (flt_mask) mask_cnt++;
      if (res_normal && normal_cyc < 0) normal_cyc = cyc;
      if (inj_mode == 1) begin
        if (flt_mask && inj_cnt < 3) begin ext_fault = 1'b1; inj_cnt++; end
        else ext_fault = 1'b0;
      end
      prev_req = chk_req;
      prev_stg = stage_en;
    end
  end

  // check-engine responder
  initial begin
    bit pend = 0;
    int pidx = 0;
    forever begin
      @(negedge clk);
      chk_done = '0;
      if (pend) begin
        chk_done[pidx] = 1'b1;
        chk_pass[pidx] = !fail_bits[pidx];
        if (fail_once) fail_bits[pidx] = 1'b0;
        pend = 0;
      end
      for (int i = 0; i < 5; i++)
        if (chk_req[i]) begin pend = 1; pidx = i; end
    end
  end

  // oscillator flag model
  initial begin
    logic prev_osc = 1'b0;
    int k = 0;
    forever begin
      @(negedge clk);
      if (osc_en && !prev_osc) k = 0;
      if (osc_en) begin
        osc_flt = (k < oclr) ? 4'b1010 : 4'b0000;
        k++;
      end else osc_flt = 4'b0000;
      prev_osc = osc_en;
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    req_n = 0; pulse_err = 0; mask_cnt = 0; normal_cyc = -1;
    inj_cnt = 0;
    for (int i = 0; i < 3; i++) rise[i] = -1;
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic wait_result(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (res_normal || res_disabled || res_fault) break;
    end
  endtask

  function automatic int outcome();
    if (res_normal) return 0;
    if (res_disabled) return 1;
    if (res_fault) return 2;
    return 3;
  endfunction

  initial begin
    int o, n;
    // R1 reset state
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(chk_req == '0 && !osc_en && stage_en == '0 && !flt_mask &&
          !res_normal && !res_disabled && !res_fault, "R1 reset outputs",
          {chk_req, osc_en, stage_en, flt_mask}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      hi_supply = VEC[v].hs; agc_auto = VEC[v].agc; gain_ok = VEC[v].gok;
      fail_bits = (VEC[v].fidx == 3'd7) ? 5'b0 : (5'b1 << VEC[v].fidx);
      fail_once = 1'b0; oclr = VEC[v].oclr; inj_mode = 0; ext_fault = 1'b0;
      do_reset();
      wait_result(3000);
      o = outcome();
      check(o == int'(VEC[v].exp), "R3 R5 R6 R9 outcome", o, VEC[v].exp);
      n = (VEC[v].fidx != 3'd7) ? VEC[v].fidx + 1 : (VEC[v].hs ? 5 : 4);
      for (int i = 0; i < n; i++)
        check(req_n > i && req_log[i] == i, "R2 R4 request order", req_log[i], i);
      if (VEC[v].exp != 2'd2)
        check(req_n == n, "R4 request count", req_n, n);
      check(pulse_err == 0, "R2 single-cycle one-hot", pulse_err, 0);
      if (VEC[v].exp == 2'd0) begin
        check(rise[1] - rise[0] == STAGGER && rise[2] - rise[1] == STAGGER,
              "R7 stagger gaps", rise[2] - rise[1], STAGGER);
        check(mask_cnt == SETTLE + 1, "R8 settle length", mask_cnt, SETTLE + 1);
        check(normal_cyc >= PON, "R10 power-on time", normal_cyc, PON);
      end
    end

    // R3 disabled is sticky, no further requests
    hi_supply = 1'b1; agc_auto = 1'b0; fail_bits = 5'b00010; fail_once = 1'b0; oclr = 3;
    do_reset();
    wait_result(3000);
    n = req_n;
    repeat (60) @(negedge clk);
    check(res_disabled && !res_normal && !res_fault, "R3 disabled held", outcome(), 1);
    check(req_n == n, "R3 no requests after disable", req_n, n);

    // R5 R4 restart after sensor-pin failure skips capacitor test
    fail_bits = 5'b01000; fail_once = 1'b1;
    do_reset();
    wait_result(3000);
    check(res_fault, "R5 pin failure gives fault", outcome(), 2);
    wait_result(1); // leave fault
    repeat (2) @(negedge clk);
    wait_result(3000);
    check(res_normal, "R5 recovers to normal", outcome(), 0);
    check(req_n == 8, "R4 no capacitor test on re-entry", req_n, 8);
    for (int i = 4; i < 8; i++)
      check(req_log[i] == i - 4, "R5 restart order", req_log[i], i - 4);

    // R8 external fault inside the settle window ignored
    fail_bits = '0; fail_once = 1'b0; inj_mode = 1;
    do_reset();
    wait_result(3000);
    check(res_normal, "R8 masked fault ignored", outcome(), 0);
    check(inj_cnt == 3, "R8 injection happened", inj_cnt, 3);
    inj_mode = 0; ext_fault = 1'b0;

    // R12 fault during normal, then rerun without capacitor test
    repeat (5) @(negedge clk);
    n = req_n;
    ext_fault = 1'b1;
    @(negedge clk); @(negedge clk);
    check(res_fault && !res_normal, "R12 fault from normal", outcome(), 2);
    repeat (10) @(negedge clk);
    check(res_fault && osc_en == 1'b0 && stage_en == '0, "R12 fault holds, stages off",
          {osc_en, stage_en}, 0);
    ext_fault = 1'b0;
    repeat (2) @(negedge clk);
    wait_result(3000);
    check(res_normal, "R12 returns to normal", outcome(), 0);
    check(req_n - n == 4, "R12 rerun skips capacitor test", req_n - n, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule